// File: doc/BRIEF.md
# PCI Interrupt Summary Controller

This block gathers level-sensitive PCI interrupt requests from a bank of expansion slots, an on-board storage controller and a secondary bus. It folds them into one host interrupt line. The requests are split across two 16-bit summary words. The low word carries the storage line and the A/B lines of every slot. The high word carries the secondary-bus line and the C/D lines of every slot. Bit 0 of the high word is the OR of everything pending in that word, and bit 0 of the low word passes that cascade upward, subject to its own enable.

Software reaches the block through a plain 16-bit register port with an address, a read strobe, a write strobe and write data. Two enable masks are read/write. Two summary words are read-only. Read data appears one cycle after the read strobe. All control and status pins are plain levels, and no pin of this block carries a valid/ready stream, so there are no back-pressure rules.

Alongside the interrupt line, the block presents the lowest-numbered pending source as an encoded vector. Software that services the source and then rereads the vector visits pending sources from the lowest index upward. Every request line passes through a two-stage synchronizer before it is masked.

Top module: `pci_irq_summary`

## Requirements
- R1: After synchronous reset, both masks read back 0, `host_irq` is 0 and `vec_valid` is 0.
- R2: A write to offset 0x54A sets the low mask and a write to 0x54C sets the high mask. A read of either offset returns the last value written. `reg_rdata` is valid in the cycle after the cycle in which `reg_rd` is high.
- R3: The low summary word is read at 0x542. Its bit 1 is the storage line, bit 2+2N is slot N line A and bit 3+2N is slot N line B. Each of these bits is set only while its line is high and the same bit of the low mask is 1.
- R4: The high summary word is read at 0x544. Its bit 1 is the secondary-bus line, bit 2+2N is slot N line C and bit 3+2N is slot N line D. Each of these bits is gated by the same bit of the high mask.
- R5: Bit 0 of the high summary word is the OR of bits 15..1 of that word.
- R6: Bit 0 of the low summary word equals bit 0 of the high word ANDed with bit 0 of the low mask.
- R7: No request is latched. A summary bit clears as soon as its line drops or its mask bit is cleared.
- R8: A change on an input line reaches the summary words and `host_irq` two clock edges after it is applied, and not after one.
- R9: `host_irq` is the OR of all 16 bits of the low summary word.
- R10: `vec_valid` equals `host_irq`. The block looks for the lowest set source bit k in the 32-bit view, where the low word is bits 0..15 and the high word is bits 16..31. Bits 0 and 16 are excluded from this search. High-word bits count only while low-word bit 0 is set. The vector is 0x800 + 16*(16+k).
- R11: Writes to 0x542, 0x544 or any other offset that is not a mask leave both masks and both summary words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_int_a | input | NUM_SLOTS | Line A per slot |
| slot_int_b | input | NUM_SLOTS | Line B per slot |
| slot_int_c | input | NUM_SLOTS | Line C per slot |
| slot_int_d | input | NUM_SLOTS | Line D per slot |
| store_int | input | 1 | On-board storage controller request |
| sec_bus_int | input | 1 | OR of secondary-bus requests |
| reg_addr | input | ADDR_W | Register offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after strobe |
| host_irq | output | 1 | Combined host interrupt |
| vec_valid | output | 1 | A vector is being presented |
| vec | output | 16 | Vector of lowest pending source |

## Verification
The hardest case to reach is a high-word source that sits behind the cascade. It must raise the host line and win the vector only while low-word bit 0 is enabled, and it must lose the vector to any pending low-word source. The bench reaches this case in steps. It holds a C or D line high with the high mask open. It then toggles mask bit 0 of the low word through the register port, and adds and removes a low-word source. After each step it compares the vector and the host line with its own model.

// File: rtl/pci_irqsum_pkg.sv
package pci_irqsum_pkg;
  localparam int WORD_W = 16;
  localparam logic [11:0] OFS_SUM_LO  = 12'h542;
  localparam logic [11:0] OFS_SUM_HI  = 12'h544;
  localparam logic [11:0] OFS_MASK_LO = 12'h54A;
  localparam logic [11:0] OFS_MASK_HI = 12'h54C;
  localparam logic [15:0] VEC_BASE = 16'h0800;
  localparam int IRQ_BASE = 16;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SUM_LO, SEL_SUM_HI, SEL_MASK_LO, SEL_MASK_HI
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [11:0] a);
    case (a)
      OFS_SUM_LO:  return SEL_SUM_LO;
      OFS_SUM_HI:  return SEL_SUM_HI;
      OFS_MASK_LO: return SEL_MASK_LO;
      OFS_MASK_HI: return SEL_MASK_HI;
      default:     return SEL_NONE;
    endcase
  endfunction

  function automatic logic [15:0] vec_of(input logic [4:0] k);
    return VEC_BASE + 16'((IRQ_BASE + int'(k)) * 16);
  endfunction
endpackage

// File: rtl/irqsum_sync.sv
module irqsum_sync #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta;
  logic [1:0]   since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      dout <= '0;
      since_rst <= '0;
    end else begin
      meta <= din;
      dout <= meta;
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
  end

  // R8: output is the input delayed by exactly two edges
  p_two_stage_r8: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/irqsum_regs.sv
module irqsum_regs
  import pci_irqsum_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] sum_lo,
  input  logic [WORD_W-1:0] sum_hi,
  output logic [WORD_W-1:0] mask_lo,
  output logic [WORD_W-1:0] mask_hi,
  output logic [WORD_W-1:0] rdata
);
  reg_sel_e sel;
  logic [WORD_W-1:0] rd_mux;

  always_comb begin
    sel = decode_ofs(12'(addr));
    case (sel)
      SEL_SUM_LO:  rd_mux = sum_lo;
      SEL_SUM_HI:  rd_mux = sum_hi;
      SEL_MASK_LO: rd_mux = mask_lo;
      SEL_MASK_HI: rd_mux = mask_hi;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_lo <= '0;
      mask_hi <= '0;
      rdata   <= '0;
    end else begin
      if (wr && sel == SEL_MASK_LO) mask_lo <= wdata;
      if (wr && sel == SEL_MASK_HI) mask_hi <= wdata;
      if (rd) rdata <= rd_mux;
    end
  end

  // R11: masks move only on a write aimed at them
  p_mask_lo_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_MASK_LO) |=> $stable(mask_lo));
  p_mask_hi_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_MASK_HI) |=> $stable(mask_hi));
  // R2: mask readback is the stored value
  p_mask_read_r2: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr && sel == SEL_MASK_LO) |=> (rdata == mask_lo));
endmodule

// File: rtl/irqsum_fold.sv
module irqsum_fold
  import pci_irqsum_pkg::*;
#(
  parameter int NUM_SLOTS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] a,
  input  logic [NUM_SLOTS-1:0] b,
  input  logic [NUM_SLOTS-1:0] c,
  input  logic [NUM_SLOTS-1:0] d,
  input  logic                 store,
  input  logic                 sec,
  input  logic [WORD_W-1:0]    mask_lo,
  input  logic [WORD_W-1:0]    mask_hi,
  output logic [WORD_W-1:0]    sum_lo,
  output logic [WORD_W-1:0]    sum_hi
);
  localparam int FIRST_SLOT_BIT = 2;

  logic [WORD_W-1:0] raw_lo, raw_hi;
  logic [WORD_W-1:0] gated_hi;
  logic unused_mask_bit;

  generate
    for (genvar n = 0; n < WORD_W; n++) begin : g_bit
      if (n == 1) begin : g_misc
        assign raw_lo[n] = store;
        assign raw_hi[n] = sec;
      end else if (n >= FIRST_SLOT_BIT &&
                   (n - FIRST_SLOT_BIT) / 2 < NUM_SLOTS) begin : g_slot
        localparam int S = (n - FIRST_SLOT_BIT) / 2;
        if (((n - FIRST_SLOT_BIT) % 2) == 0) begin : g_even
          assign raw_lo[n] = a[S];
          assign raw_hi[n] = c[S];
        end else begin : g_odd
          assign raw_lo[n] = b[S];
          assign raw_hi[n] = d[S];
        end
      end else begin : g_none
        assign raw_lo[n] = 1'b0;
        assign raw_hi[n] = 1'b0;
      end
    end
  endgenerate

  assign gated_hi = raw_hi & mask_hi;
  assign sum_hi = {gated_hi[WORD_W-1:1], |gated_hi[WORD_W-1:1]};
  assign sum_lo = {raw_lo[WORD_W-1:1] & mask_lo[WORD_W-1:1],
                   sum_hi[0] & mask_lo[0]};
  assign unused_mask_bit = mask_hi[0] ^ raw_lo[0] ^ raw_hi[0];

  // R3: every low bit respects its enable
  p_lo_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (sum_lo & ~mask_lo) == '0);
  // R4: every high source bit respects its enable
  p_hi_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (sum_hi[WORD_W-1:1] & ~mask_hi[WORD_W-1:1]) == '0);
  // R6: cascade bit only with a pending high word
  p_cascade_r6: assert property (@(posedge clk) disable iff (rst)
    sum_lo[0] |-> sum_hi[0]);
  // R5: high summary bit never set over an empty word
  p_hi_or_r5: assert property (@(posedge clk) disable iff (rst)
    (sum_hi[WORD_W-1:1] == '0) |-> !sum_hi[0]);
endmodule

// File: rtl/irqsum_pick.sv
module irqsum_pick
  import pci_irqsum_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] sum_lo,
  input  logic [WORD_W-1:0] sum_hi,
  output logic              vec_valid,
  output logic [15:0]       vec
);
  localparam int VIEW_W = 2 * WORD_W;

  logic [VIEW_W-1:0] view;
  logic [4:0]        idx;
  logic              found;
  logic              unused_hi0;

  always_comb begin
    view = '0;
    view[WORD_W-1:1] = sum_lo[WORD_W-1:1];
    if (sum_lo[0]) view[VIEW_W-1:WORD_W+1] = sum_hi[WORD_W-1:1];
    idx = '0;
    found = 1'b0;
    for (int i = VIEW_W - 1; i >= 0; i--) begin
      if (view[i]) begin
        idx = 5'(i);
        found = 1'b1;
      end
    end
  end

  assign unused_hi0 = sum_hi[0];
  assign vec_valid = found;
  assign vec = found ? vec_of(idx) : '0;

  // R10: vectors are 16-aligned and start at the first source
  p_vec_align_r10: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec[3:0] == 4'h0 && vec >= 16'h0910 && vec <= 16'h0AF0));
endmodule

// File: rtl/pci_irq_summary.sv
module pci_irq_summary
  import pci_irqsum_pkg::*;
#(
  parameter int NUM_SLOTS = 7,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] slot_int_a,
  input  logic [NUM_SLOTS-1:0] slot_int_b,
  input  logic [NUM_SLOTS-1:0] slot_int_c,
  input  logic [NUM_SLOTS-1:0] slot_int_d,
  input  logic                 store_int,
  input  logic                 sec_bus_int,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  output logic                 host_irq,
  output logic                 vec_valid,
  output logic [15:0]          vec
);
  localparam int LINES = 4 * NUM_SLOTS + 2;

  logic [LINES-1:0]     line_raw, line_sync;
  logic [NUM_SLOTS-1:0] sa, sb, sc, sd;
  logic                 s_store, s_sec;
  logic [WORD_W-1:0]    mask_lo, mask_hi, sum_lo, sum_hi;

  assign line_raw = {sec_bus_int, store_int, slot_int_d, slot_int_c,
                     slot_int_b, slot_int_a};

  irqsum_sync #(.W(LINES)) i_sync (
    .clk(clk), .rst(rst), .din(line_raw), .dout(line_sync)
  );

  assign {s_sec, s_store, sd, sc, sb, sa} = line_sync;

  irqsum_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .rd(reg_rd), .wr(reg_wr),
    .wdata(reg_wdata), .sum_lo(sum_lo), .sum_hi(sum_hi),
    .mask_lo(mask_lo), .mask_hi(mask_hi), .rdata(reg_rdata)
  );

  irqsum_fold #(.NUM_SLOTS(NUM_SLOTS)) i_fold (
    .clk(clk), .rst(rst), .a(sa), .b(sb), .c(sc), .d(sd),
    .store(s_store), .sec(s_sec), .mask_lo(mask_lo), .mask_hi(mask_hi),
    .sum_lo(sum_lo), .sum_hi(sum_hi)
  );

  irqsum_pick i_pick (
    .clk(clk), .rst(rst), .sum_lo(sum_lo), .sum_hi(sum_hi),
    .vec_valid(vec_valid), .vec(vec)
  );

  assign host_irq = |sum_lo;

  // R10/R9: the vector is offered exactly when the host line is up
  p_host_vec_r10: assert property (@(posedge clk) disable iff (rst)
    host_irq == vec_valid);
  // R9: host line silent while the low mask is closed
  p_host_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (mask_lo == '0) |-> !host_irq);
endmodule

// File: tb/test_pci_irq_summary.sv
module test_pci_irq_summary;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] la = '0, lb = '0, lc = '0, ld = '0;
  logic lst = 1'b0, lsec = 1'b0;
  logic [11:0] addr = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic host_irq, vec_valid;
  logic [15:0] vec;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_lo = '0, m_hi = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_irq_summary #(.NUM_SLOTS(NS), .ADDR_W(12)) i_pci_irq_summary (
    .clk(clk), .rst(rst), .slot_int_a(la), .slot_int_b(lb),
    .slot_int_c(lc), .slot_int_d(ld), .store_int(lst), .sec_bus_int(lsec),
    .reg_addr(addr), .reg_rd(rd), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .host_irq(host_irq), .vec_valid(vec_valid), .vec(vec)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_hi();
    logic [15:0] w = '0;
    w[1] = lsec;
    for (int n = 0; n < NS; n++) begin
      w[2+2*n] = lc[n];
      w[3+2*n] = ld[n];
    end
    w = w & m_hi;
    w[0] = |w[15:1];
    return w;
  endfunction

  function automatic logic [15:0] exp_lo();
    logic [15:0] w = '0;
    logic [15:0] h = exp_hi();
    w[1] = lst;
    for (int n = 0; n < NS; n++) begin
      w[2+2*n] = la[n];
      w[3+2*n] = lb[n];
    end
    w[0] = h[0];
    return w & m_lo;
  endfunction

  function automatic logic [16:0] exp_vec();
    logic [31:0] v = '0;
    logic [15:0] lo = exp_lo();
    logic [15:0] hi = exp_hi();
    v[15:1] = lo[15:1];
    if (lo[0]) v[31:17] = hi[15:1];
    for (int k = 1; k < 32; k++)
      if (v[k]) return {1'b1, 16'(16'h0800 + 16 * (16 + k))};
    return 17'h0;
  endfunction

  task automatic reg_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
    if (a == 12'h54A) m_lo = d;
    if (a == 12'h54C) m_hi = d;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(posedge clk); #1;
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic clear_lines();
    @(negedge clk);
    la = '0; lb = '0; lc = '0; ld = '0; lst = 1'b0; lsec = 1'b0;
    settle();
  endtask

  task automatic check_outputs(input string req);
    logic [16:0] e = exp_vec();
    logic [15:0] v;
    chk({req, " host"}, 32'(host_irq), 32'(|exp_lo()));
    chk({req, " valid"}, 32'(vec_valid), 32'(e[16]));
    if (e[16]) chk({req, " vec"}, 32'(vec), 32'(e[15:0]));
    reg_read(12'h542, v);
    chk({req, " sum_lo"}, 32'(v), 32'(exp_lo()));
    reg_read(12'h544, v);
    chk({req, " sum_hi"}, 32'(v), 32'(exp_hi()));
  endtask

  task automatic t_reset();
    logic [15:0] v;
    reg_read(12'h54A, v); chk("R1 mask_lo", 32'(v), 32'h0);
    reg_read(12'h54C, v); chk("R1 mask_hi", 32'(v), 32'h0);
    chk("R1 host", 32'(host_irq), 32'h0);
    chk("R1 valid", 32'(vec_valid), 32'h0);
  endtask

  task automatic t_mask_rw();
    logic [15:0] v;
    reg_write(12'h54A, 16'hA5C3);
    reg_write(12'h54C, 16'h3C5A);
    reg_read(12'h54A, v); chk("R2 mask_lo", 32'(v), 32'hA5C3);
    reg_read(12'h54C, v); chk("R2 mask_hi", 32'(v), 32'h3C5A);
  endtask

  task automatic t_layout();
    reg_write(12'h54A, 16'hFFFE);
    reg_write(12'h54C, 16'hFFFF);
    for (int n = 0; n < NS; n++) begin
      @(negedge clk);
      la = '0; lb = '0; lc = '0; ld = '0;
      la[n] = 1'b1;
      settle();
      check_outputs("R3 slotA");
      @(negedge clk);
      la = '0; lb[n] = 1'b1; ld[n] = 1'b1;
      settle();
      check_outputs("R3 slotB R4 slotD");
    end
    @(negedge clk);
    la = '0; lb = '0; ld = '0; lst = 1'b1; lsec = 1'b1; lc = 7'h55;
    settle();
    check_outputs("R3 store R4 sec R5");
    reg_write(12'h54A, 16'h5556);
    reg_write(12'h54C, 16'h00F2);
    check_outputs("R3 R4 partial masks");
    clear_lines();
  endtask

  task automatic t_cascade();
    reg_write(12'h54A, 16'hFFFF);
    reg_write(12'h54C, 16'hFFFF);
    @(negedge clk);
    lc[0] = 1'b1;
    settle();
    check_outputs("R6 R10 cascade on");
    chk("R10 vec C0", 32'(vec), 32'h0A20);
    @(negedge clk);
    lb[2] = 1'b1;
    settle();
    chk("R10 low wins", 32'(vec), 32'h0970);
    reg_write(12'h54A, 16'hFFFE);
    @(negedge clk);
    lb[2] = 1'b0;
    settle();
    check_outputs("R6 cascade blocked");
    chk("R6 host off", 32'(host_irq), 32'h0);
    reg_write(12'h54A, 16'hFFFF);
    @(negedge clk);
    lc[0] = 1'b0; ld[6] = 1'b1; lsec = 1'b1;
    settle();
    chk("R10 sec first", 32'(vec), 32'h0A10);
    @(negedge clk);
    lsec = 1'b0;
    settle();
    chk("R10 D6 last", 32'(vec), 32'h0AF0);
    @(negedge clk);
    lst = 1'b1;
    settle();
    chk("R10 store", 32'(vec), 32'h0910);
    check_outputs("R9 mix");
    clear_lines();
  endtask

  task automatic t_level();
    reg_write(12'h54A, 16'hFFFF);
    @(negedge clk);
    la[4] = 1'b1;
    settle();
    chk("R7 set", 32'(host_irq), 32'h1);
    reg_write(12'h54A, 16'hFFFF & ~(16'h1 << 10));
    chk("R7 mask drop", 32'(host_irq), 32'h0);
    check_outputs("R7 mask drop");
    reg_write(12'h54A, 16'hFFFF);
    chk("R7 reenable", 32'(host_irq), 32'h1);
    @(negedge clk);
    la[4] = 1'b0;
    settle();
    chk("R7 line drop", 32'(host_irq), 32'h0);
  endtask

  task automatic t_latency();
    reg_write(12'h54A, 16'hFFFF);
    @(negedge clk);
    la[3] = 1'b1;
    @(posedge clk); #1;
    chk("R8 one edge", 32'(host_irq), 32'h0);
    @(posedge clk); #1;
    chk("R8 two edges", 32'(host_irq), 32'h1);
    @(negedge clk);
    la[3] = 1'b0;
    @(posedge clk); #1;
    chk("R8 fall one edge", 32'(host_irq), 32'h1);
    @(posedge clk); #1;
    chk("R8 fall two edges", 32'(host_irq), 32'h0);
  endtask

  task automatic t_ignore();
    logic [15:0] v;
    reg_write(12'h54A, 16'h00F0);
    reg_write(12'h54C, 16'h0F00);
    @(negedge clk);
    la = 7'h7F; lc = 7'h7F;
    settle();
    reg_write(12'h542, 16'hFFFF);
    reg_write(12'h544, 16'hFFFF);
    reg_write(12'h540, 16'hFFFF);
    reg_write(12'h54E, 16'hFFFF);
    reg_read(12'h54A, v); chk("R11 mask_lo", 32'(v), 32'h00F0);
    reg_read(12'h54C, v); chk("R11 mask_hi", 32'(v), 32'h0F00);
    check_outputs("R11 summary");
    clear_lines();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_mask_rw();
    t_layout();
    t_cascade();
    t_level();
    t_latency();
    t_ignore();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule